// File: doc/BRIEF.md
# Configuration Port Decoder

This block sits in a host bridge. It watches processor I/O accesses and claims two dword ports: a configuration address port and a configuration data window one dword above it. A full 32-bit write to the address port loads an address register. That register holds an enable flag, a bus number, a device number, a function number and a dword register index. Each later access to the data window is turned into one configuration read or write request toward a downstream responder. The request carries the fields from the register and the byte lanes of the access.

The processor side uses a single-cycle strobe with a dword address, four byte enables and 32-bit lane-positioned data. The block answers every claimed access with a one-cycle acknowledge. The downstream side has a valid/ready request, followed by a response pulse that carries data and a no-device flag. Only one configuration transaction is in flight at a time. A data-window access made while the enable flag is clear, or made with a lane pattern that is not a legal byte, halfword or dword, completes locally and returns all ones.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the address register is zero, `io_ack_o` and `cfg_req_o` are low, and a data-window read returns 0xFFFFFFFF with no request issued.
- R2: A strobe with `io_be_i`=4'b1111 and `io_we_i`=1 at the address port (byte address 0xCF8) loads the register. Bit 31 is the enable and bits 23:2 are the fields. Bits 30:24 and 1:0 read back zero, so writing 0x80000000 reads back exactly 0x80000000. A 4'b1111 read of the address port returns the register with `io_ack_o` one cycle after the strobe.
- R3: A request carries the bus from register bits 23:16, the device from bits 15:11, the function from bits 10:8 and the register index from bits 7:2.
- R4: A single-lane access to the data window with `io_be_i` bit n set (byte 0xCFC+n) issues a request with `cfg_be_o` equal to `io_be_i`. Read data is returned lane-positioned on `io_rdata_o` exactly as the responder supplied it.
- R5: The legal data-window lane patterns are 0001, 0010, 0100, 1000, 0011, 1100 and 1111. Any other pattern issues no request and is acknowledged one cycle after the strobe, with 0xFFFFFFFF on reads.
- R6: While the enable bit is clear, a data-window access issues no request (writes are dropped) and is acknowledged one cycle after the strobe, with 0xFFFFFFFF on reads.
- R7: An address-port access whose byte enables are not 4'b1111 (for example a byte at 0xCF8 or 0xCFB) is not claimed: `io_hit_o` stays low, no acknowledge follows, and the register keeps its value.
- R8: An enabled, legal data access raises `cfg_req_o` the cycle after the strobe. The request and its fields hold steady until `cfg_ready_i` is high, and `io_ack_o` pulses one cycle after `cfg_rsp_valid_i`.
- R9: A read response with `cfg_rsp_err_i` set returns 0xFFFFFFFF.
- R10: Strobes that arrive while a configuration transaction is outstanding are ignored: they do not change the register and are not acknowledged.
- R11: `io_hit_o` is high in a strobe cycle to the data window, or to the address port with all four byte enables; it is low for any other address.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_req_i | input | 1 | Single-cycle I/O access strobe |
| io_we_i | input | 1 | 1 = write, 0 = read |
| io_waddr_i | input | IO_AW-2 | Dword address of the I/O access |
| io_be_i | input | 4 | Byte-lane enables |
| io_wdata_i | input | 32 | Lane-positioned write data |
| io_hit_o | output | 1 | Access is claimed by this block |
| io_ack_o | output | 1 | One-cycle completion pulse |
| io_rdata_o | output | 32 | Read data, valid with io_ack_o |
| cfg_req_o | output | 1 | Configuration request valid |
| cfg_ready_i | input | 1 | Responder accepts the request |
| cfg_we_o | output | 1 | Request is a write |
| cfg_bus_o | output | 8 | Bus number |
| cfg_dev_o | output | 5 | Device number |
| cfg_func_o | output | 3 | Function number |
| cfg_reg_o | output | 6 | Dword register index |
| cfg_be_o | output | 4 | Byte enables of the request |
| cfg_wdata_o | output | 32 | Write data of the request |
| cfg_rsp_valid_i | input | 1 | Response pulse |
| cfg_rsp_data_i | input | 32 | Response read data |
| cfg_rsp_err_i | input | 1 | No device answered |

## Verification
Accesses that complete locally (address-port reads and writes, disabled or illegal data accesses) must show `io_ack_o` at the first falling edge after the strobe. The bench therefore counts zero extra cycles for them and fails any other count. A forwarded access must raise `cfg_req_o` in the cycle after the strobe. With no stall, the acknowledge comes two falling edges later, and each cycle of withheld `cfg_ready_i` adds one. The bench's responder drives ready and response at falling edges, and the bench compares the measured wait against that figure. Outputs are read only at falling edges, half a period from the registers that drive them.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned DEV_W   = 5;
  localparam int unsigned FUNC_W  = 3;
  localparam int unsigned REG_W   = 6;
  localparam int unsigned FIELD_W = BUS_W + DEV_W + FUNC_W + REG_W;  // bits 23:2

  typedef enum logic [1:0] {
    XS_IDLE,
    XS_REQ,
    XS_RSP
  } xact_state_e;

  // byte, aligned halfword or full dword only
  function automatic logic lanes_ok(input logic [3:0] be);
    case (be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000,
      4'b0011, 4'b1100, 4'b1111: lanes_ok = 1'b1;
      default:                   lanes_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_io_decode.sv
module cfg_io_decode #(
  parameter int unsigned       IO_AW     = 16,
  parameter logic [IO_AW-1:0]  ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0]  DATA_PORT = 16'hCFC
) (
  input  logic             req_i,
  input  logic [IO_AW-1:2] waddr_i,
  input  logic [3:0]       be_i,
  output logic             addr_full_o,
  output logic             addr_part_o,
  output logic             data_o,
  output logic             lanes_ok_o
);
  import cfg_port_pkg::*;

  logic at_addr, at_data;

  assign at_addr     = (waddr_i == ADDR_PORT[IO_AW-1:2]);
  assign at_data     = (waddr_i == DATA_PORT[IO_AW-1:2]);
  assign addr_full_o = req_i && at_addr && (be_i == 4'b1111);
  assign addr_part_o = req_i && at_addr && (be_i != 4'b1111);
  assign data_o      = req_i && at_data;
  assign lanes_ok_o  = lanes_ok(be_i);
endmodule

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_port_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] fld_i,
  output logic               en_o,
  output logic [DW-1:0]      addr_o,
  output logic [BUS_W-1:0]   bus_o,
  output logic [DEV_W-1:0]   dev_o,
  output logic [FUNC_W-1:0]  func_o,
  output logic [REG_W-1:0]   reg_o
);
  logic               en_q;
  logic [FIELD_W-1:0] fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      fld_q <= '0;
    end else if (wr_i) begin
      en_q  <= en_i;
      fld_q <= fld_i;
    end
  end

  assign en_o   = en_q;
  assign addr_o = {en_q, 7'b0, fld_q, 2'b00};
  assign {bus_o, dev_o, func_o, reg_o} = fld_q;
endmodule

// File: rtl/cfg_xact_fsm.sv
module cfg_xact_fsm
  import cfg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              local_i,
  input  logic [DW-1:0]     local_rdata_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  bus_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [3:0]        be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic [DW-1:0]     rdata_o,
  output logic              cfg_req_o,
  input  logic              cfg_ready_i,
  output logic              cfg_we_o,
  output logic [BUS_W-1:0]  cfg_bus_o,
  output logic [DEV_W-1:0]  cfg_dev_o,
  output logic [FUNC_W-1:0] cfg_func_o,
  output logic [REG_W-1:0]  cfg_reg_o,
  output logic [3:0]        cfg_be_o,
  output logic [DW-1:0]     cfg_wdata_o,
  input  logic              cfg_rsp_valid_i,
  input  logic [DW-1:0]     cfg_rsp_data_i,
  input  logic              cfg_rsp_err_i
);
  xact_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= XS_IDLE;
      ack_o       <= 1'b0;
      rdata_o     <= '0;
      cfg_we_o    <= 1'b0;
      cfg_bus_o   <= '0;
      cfg_dev_o   <= '0;
      cfg_func_o  <= '0;
      cfg_reg_o   <= '0;
      cfg_be_o    <= '0;
      cfg_wdata_o <= '0;
    end else begin
      ack_o <= 1'b0;
      case (state_q)
        XS_IDLE: begin
          if (start_i) begin
            state_q     <= XS_REQ;
            cfg_we_o    <= we_i;
            cfg_bus_o   <= bus_i;
            cfg_dev_o   <= dev_i;
            cfg_func_o  <= func_i;
            cfg_reg_o   <= reg_i;
            cfg_be_o    <= be_i;
            cfg_wdata_o <= wdata_i;
          end else if (local_i) begin
            ack_o   <= 1'b1;
            rdata_o <= local_rdata_i;
          end
        end
        XS_REQ: if (cfg_ready_i) state_q <= XS_RSP;
        XS_RSP: begin
          if (cfg_rsp_valid_i) begin
            state_q <= XS_IDLE;
            ack_o   <= 1'b1;
            if (cfg_we_o)           rdata_o <= '0;
            else if (cfg_rsp_err_i) rdata_o <= '1;
            else                    rdata_o <= cfg_rsp_data_i;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign cfg_req_o = (state_q == XS_REQ);
  assign busy_o    = (state_q != XS_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_o && !cfg_ready_i) |=> (cfg_req_o && $stable({cfg_we_o, cfg_bus_o, cfg_dev_o,
      cfg_func_o, cfg_reg_o, cfg_be_o, cfg_wdata_o}))); // R8
  AST_ACK_AFTER_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XS_RSP && cfg_rsp_valid_i) |=> ack_o); // R8
  AST_REQ_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> lanes_ok(cfg_be_o)); // R5
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter int unsigned      IO_AW     = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_req_i,
  input  logic             io_we_i,
  input  logic [IO_AW-1:2] io_waddr_i,
  input  logic [3:0]       io_be_i,
  input  logic [31:0]      io_wdata_i,
  output logic             io_hit_o,
  output logic             io_ack_o,
  output logic [31:0]      io_rdata_o,
  output logic             cfg_req_o,
  input  logic             cfg_ready_i,
  output logic             cfg_we_o,
  output logic [7:0]       cfg_bus_o,
  output logic [4:0]       cfg_dev_o,
  output logic [2:0]       cfg_func_o,
  output logic [5:0]       cfg_reg_o,
  output logic [3:0]       cfg_be_o,
  output logic [31:0]      cfg_wdata_o,
  input  logic             cfg_rsp_valid_i,
  input  logic [31:0]      cfg_rsp_data_i,
  input  logic             cfg_rsp_err_i
);
  logic addr_full, addr_part, data_hit, lanes_ok_w;
  logic busy, accept, en;
  logic start, local_done;
  logic [DW-1:0] addr_val, local_rdata;
  logic [BUS_W-1:0]  r_bus;
  logic [DEV_W-1:0]  r_dev;
  logic [FUNC_W-1:0] r_func;
  logic [REG_W-1:0]  r_reg;

  cfg_io_decode #(
    .IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .req_i(io_req_i), .waddr_i(io_waddr_i), .be_i(io_be_i),
    .addr_full_o(addr_full), .addr_part_o(addr_part),
    .data_o(data_hit), .lanes_ok_o(lanes_ok_w)
  );

  assign accept = !busy && (addr_full || data_hit);

  cfg_addr_reg u_areg (
    .clk_i, .rst_ni,
    .wr_i(accept && addr_full && io_we_i),
    .en_i(io_wdata_i[31]), .fld_i(io_wdata_i[23:2]),
    .en_o(en), .addr_o(addr_val),
    .bus_o(r_bus), .dev_o(r_dev), .func_o(r_func), .reg_o(r_reg)
  );

  assign start       = accept && data_hit && en && lanes_ok_w;
  assign local_done  = accept && !start;
  assign local_rdata = (addr_full && !io_we_i) ? addr_val :
                       addr_full               ? '0 : '1;

  cfg_xact_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .local_i(local_done), .local_rdata_i(local_rdata),
    .we_i(io_we_i), .bus_i(r_bus), .dev_i(r_dev), .func_i(r_func), .reg_i(r_reg),
    .be_i(io_be_i), .wdata_i(io_wdata_i),
    .busy_o(busy), .ack_o(io_ack_o), .rdata_o(io_rdata_o),
    .cfg_req_o, .cfg_ready_i, .cfg_we_o, .cfg_bus_o, .cfg_dev_o,
    .cfg_func_o, .cfg_reg_o, .cfg_be_o, .cfg_wdata_o,
    .cfg_rsp_valid_i, .cfg_rsp_data_i, .cfg_rsp_err_i
  );

  assign io_hit_o = addr_full || data_hit;

  AST_NO_REQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_req_o) |-> $past(en)); // R6
  AST_PARTIAL_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_part |=> $stable(addr_val)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && io_req_i) |=> $stable(addr_val)); // R10
  AST_ADDR_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_ack_o && !cfg_req_o) |-> (addr_val[1:0] == 2'b00)); // R2
endmodule

// File: tb/cfg_port_decoder_bench.sv
`timescale 1ns/1ps
module cfg_port_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        io_req = 0, io_we = 0;
  logic [15:2] io_waddr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_hit, io_ack;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_ready = 0, cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        rsp_valid = 0, rsp_err = 0;
  logic [31:0] rsp_data = '0;

  cfg_port_decoder u_cfg_port_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .io_req_i(io_req), .io_we_i(io_we), .io_waddr_i(io_waddr), .io_be_i(io_be),
    .io_wdata_i(io_wdata), .io_hit_o(io_hit), .io_ack_o(io_ack), .io_rdata_o(io_rdata),
    .cfg_req_o(cfg_req), .cfg_ready_i(cfg_ready), .cfg_we_o(cfg_we),
    .cfg_bus_o(cfg_bus), .cfg_dev_o(cfg_dev), .cfg_func_o(cfg_func), .cfg_reg_o(cfg_reg),
    .cfg_be_o(cfg_be), .cfg_wdata_o(cfg_wdata),
    .cfg_rsp_valid_i(rsp_valid), .cfg_rsp_data_i(rsp_data), .cfg_rsp_err_i(rsp_err)
  );

  int checks = 0, fails = 0, cyc = 0;
  int stall = 0, req_cnt = 0;
  logic rsp_phase = 0;
  logic        c_we;
  logic [7:0]  c_bus;
  logic [4:0]  c_dev;
  logic [2:0]  c_func;
  logic [5:0]  c_reg;
  logic [3:0]  c_be;
  logic [31:0] c_wdata;

  localparam logic [15:0] AP = 16'hCF8, DP = 16'hCFC;

  function automatic logic [31:0] pat(input logic [7:0] b, input logic [4:0] d,
                                      input logic [2:0] f, input logic [5:0] r);
    return {r, 2'b01, f, d, b, 8'hA5};
  endfunction

  function automatic logic legal(input logic [3:0] be);
    return be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111};
  endfunction

  // responder: ready/response driven at falling edges
  initial forever begin
    @(negedge clk);
    if (rsp_phase) begin
      rsp_valid = 1; rsp_err = (c_bus == 8'hEE);
      rsp_data  = pat(c_bus, c_dev, c_func, c_reg);
      rsp_phase = 0; cfg_ready = 0;
    end else begin
      rsp_valid = 0;
      if (cfg_req) begin
        if (stall > 0) begin cfg_ready = 0; stall--; end
        else begin
          cfg_ready = 1; req_cnt++; rsp_phase = 1;
          c_we = cfg_we; c_bus = cfg_bus; c_dev = cfg_dev; c_func = cfg_func;
          c_reg = cfg_reg; c_be = cfg_be; c_wdata = cfg_wdata;
        end
      end else cfg_ready = 0;
    end
  end

  always @(posedge clk) cyc++;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic io_op(input logic we, input logic [15:0] ba, input logic [3:0] be,
                       input logic [31:0] wd, input int maxw,
                       output logic got, output int lat, output logic [31:0] rd, output logic hit);
    @(negedge clk);
    io_req = 1; io_we = we; io_waddr = ba[15:2]; io_be = be; io_wdata = wd;
    #1 hit = io_hit;
    @(negedge clk);
    io_req = 0;
    got = 0; lat = 0; rd = '0;
    for (int i = 0; i <= maxw; i++) begin
      if (io_ack) begin got = 1; lat = i; rd = io_rdata; break; end
      @(negedge clk);
    end
  endtask

  // enable+fields / lanes / we / wdata
  localparam int NV = 14;
  localparam logic [68:0] VECS [NV] = '{
    {32'h8000_0000, 4'b1111, 1'b0, 32'h0},
    {32'h8012_3A44, 4'b0001, 1'b0, 32'h0},
    {32'h8012_3A44, 4'b0010, 1'b0, 32'h0},
    {32'h8012_3A44, 4'b0100, 1'b0, 32'h0},
    {32'h8012_3A44, 4'b1000, 1'b0, 32'h0},
    {32'h80AB_FFFC, 4'b0011, 1'b0, 32'h0},
    {32'h80AB_FFFC, 4'b1100, 1'b1, 32'h1234_5678},
    {32'h8000_0800, 4'b1111, 1'b1, 32'hDEAD_BEEF},
    {32'h80EE_0000, 4'b1111, 1'b0, 32'h0},
    {32'h0012_3A44, 4'b1111, 1'b0, 32'h0},
    {32'h8012_0000, 4'b0110, 1'b0, 32'h0},
    {32'h8012_0000, 4'b0101, 1'b1, 32'h5555_AAAA},
    {32'h80FF_FFFF, 4'b1111, 1'b0, 32'h0},
    {32'h7FFF_FFFF, 4'b1111, 1'b0, 32'h0}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cyc == 100000);
    fails++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", cyc, 0);
    summary();
  end

  initial begin
    logic got, hit; int lat, n0; logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk(!io_ack && !cfg_req, "R1 reset outputs", {30'b0, io_ack, cfg_req}, 0);
    rst_n = 1;
    io_op(0, AP, 4'b1111, 0, 5, got, lat, rd, hit);
    chk(got && rd == 32'h0, "R1 reset address register", rd, 0);
    n0 = req_cnt;
    io_op(0, DP, 4'b1111, 0, 5, got, lat, rd, hit);
    chk(got && rd == 32'hFFFF_FFFF && req_cnt == n0, "R1 data read after reset", rd, 32'hFFFF_FFFF);

    // R2 presence pattern
    io_op(1, AP, 4'b1111, 32'h8000_0000, 5, got, lat, rd, hit);
    chk(got && lat == 0, "R2 address write ack", lat, 0);
    io_op(0, AP, 4'b1111, 0, 5, got, lat, rd, hit);
    chk(got && lat == 0 && rd == 32'h8000_0000, "R2 presence readback", rd, 32'h8000_0000);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [31:0] a, wd, exp_rd, amask; logic [3:0] be; logic we, fwd;
      {a, be, we, wd} = VECS[v];
      amask = a & 32'h80FF_FFFC;
      io_op(1, AP, 4'b1111, a, 5, got, lat, rd, hit);
      io_op(0, AP, 4'b1111, 0, 5, got, lat, rd, hit);
      chk(got && rd == amask, "R2 register readback", rd, amask);
      fwd = a[31] && legal(be);
      n0 = req_cnt;
      io_op(we, DP + 16'(0), be, wd, 20, got, lat, rd, hit);
      chk(hit, "R11 data window claimed", {31'b0, hit}, 1);
      chk(got && (req_cnt - n0) == (fwd ? 1 : 0), fwd ? "R4 request issued" : "R5 R6 no request",
          req_cnt - n0, fwd ? 1 : 0);
      chk(lat == (fwd ? 2 : 0), fwd ? "R8 forwarded latency" : "R6 local latency", lat, fwd ? 2 : 0);
      if (fwd) begin
        chk({c_bus, c_dev, c_func, c_reg} == a[23:2], "R3 request fields",
            {10'b0, c_bus, c_dev, c_func, c_reg}, {10'b0, a[23:2]});
        chk(c_be == be && c_we == we, "R4 request lanes", {27'b0, c_we, c_be}, {27'b0, we, be});
        if (we) chk(c_wdata == wd, "R4 write data", c_wdata, wd);
      end
      if (!we) begin
        exp_rd = (!fwd || a[23:16] == 8'hEE) ? 32'hFFFF_FFFF : pat(a[23:16], a[15:11], a[10:8], a[7:2]);
        chk(rd == exp_rd, fwd ? (a[23:16] == 8'hEE ? "R9 no device" : "R4 read data") : "R5 R6 all ones", rd, exp_rd);
      end
    end

    // R7 partial address-port accesses
    io_op(1, AP, 4'b1111, 32'h8012_3A44, 5, got, lat, rd, hit);
    io_op(1, AP, 4'b0001, 32'h0000_00FF, 5, got, lat, rd, hit);
    chk(!hit && !got, "R7 byte at 0xCF8 unclaimed", {30'b0, hit, got}, 0);
    io_op(1, AP, 4'b1000, 32'h0100_0000, 5, got, lat, rd, hit);
    chk(!hit && !got, "R7 byte at 0xCFB unclaimed", {30'b0, hit, got}, 0);
    io_op(0, AP, 4'b1111, 0, 5, got, lat, rd, hit);
    chk(rd == 32'h8012_3A44, "R7 register unchanged", rd, 32'h8012_3A44);

    // R11 unrelated port
    io_op(0, 16'h0080, 4'b1111, 0, 5, got, lat, rd, hit);
    chk(!hit && !got, "R11 other port unclaimed", {30'b0, hit, got}, 0);

    // R8 stalled ready
    stall = 3; n0 = req_cnt;
    io_op(0, DP, 4'b0100, 0, 20, got, lat, rd, hit);
    chk(got && lat == 5 && req_cnt - n0 == 1, "R8 stall latency", lat, 5);
    chk(rd == pat(8'h12, 5'd7, 3'd2, 6'h11), "R8 data after stall", rd, pat(8'h12, 5'd7, 3'd2, 6'h11));

    // R10 strobe while busy
    stall = 4; n0 = req_cnt;
    @(negedge clk);
    io_req = 1; io_we = 0; io_waddr = DP[15:2]; io_be = 4'b1111;
    @(negedge clk);
    io_we = 1; io_waddr = AP[15:2]; io_wdata = 32'h80FF_0000;
    @(negedge clk);
    io_req = 0;
    got = 0;
    for (int i = 0; i < 20; i++) begin
      if (io_ack) begin got = 1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    chk(got && !io_ack && req_cnt - n0 == 1, "R10 single completion", req_cnt - n0, 1);
    io_op(0, AP, 4'b1111, 0, 5, got, lat, rd, hit);
    chk(rd == 32'h8012_3A44, "R10 register kept", rd, 32'h8012_3A44);

    summary();
  end
endmodule